// File: doc/BRIEF.md
# Board configuration control registers

This block is a small memory-mapped register slice of a board system controller. Software reaches other parts of the board through three configuration registers: a data word, a control word and a status word. Writing the control word is itself the command. The block posts a completion status at once. It recognises two exact motherboard command words, which become one-cycle shutdown and reboot request pulses, and it flags any other command word as an error.

A static board-identifier input selects the register map. On the configuration-capable variant the three configuration registers are present, and the legacy reset-control register is reserved. On every other variant the configuration registers are absent, and the reset-control register is live behind a lock word: a write to it takes effect only while the lock register holds the unlock key.

The bus side is a plain synchronous 32-bit port with a one-cycle write strobe and a read strobe. Read data is decoded combinationally from the byte offset. A bad-address pulse marks any access that hits nothing.

Top module: `brd_cfg_regs`

## Requirements
- R1: After reset every register reads zero: lock word, reset level, data, control and status. No request pulse is active and the bad-address flag is low.
- R2: The data register at offset 0xA0 returns the last full 32-bit value written to it.
- R3: A write to the control register at offset 0xA4 stores the value with bits 18 and 19 cleared, and a read returns that masked value.
- R4: Every control-register write replaces the whole status register at offset 0xA8. Status bit 0 (complete) is set to 1, whatever the status held before.
- R5: When the masked control value equals 0xC0800000, shutdown_req is raised and status reads 1. This includes a written value of 0xC08C0000, because bits 18 and 19 are cleared before the compare.
- R6: When the masked control value equals 0xC0900000, reboot_req is raised and status reads 1.
- R7: Any other masked control value raises no request, and the status register reads 3: complete plus error in bit 1.
- R8: A direct write to the status register keeps only bits 1:0 of the written data.
- R9: When board_id differs from 0x190, the offsets 0xA0, 0xA4 and 0xA8 read zero, ignore writes and pulse bad_addr.
- R10: When board_id equals 0x190, the reset-control register at offset 0x40 reads zero and ignores writes. It raises no reset request and does not pulse bad_addr.
- R11: When board_id differs from 0x190, a write to offset 0x40 updates the reset level only while the lock register at offset 0x20 holds UNLOCK_KEY. Such an accepted write with bit 8 set raises board_reset_req.
- R12: Every request pulse lasts exactly one clock cycle and appears in the cycle after the triggering write. At most one of shutdown_req and reboot_req is high at a time.
- R13: Any read or write to an offset that is not mapped, including an offset that is not a multiple of 4, pulses bad_addr for one cycle in the cycle after the access, and reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| board_id | input | 12 | Static board-variant identifier |
| addr | input | 8 | Byte offset of the access |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| bad_addr | output | 1 | One-cycle pulse after an access to an unmapped or gated offset |
| shutdown_req | output | 1 | One-cycle system shutdown request |
| reboot_req | output | 1 | One-cycle system reboot request |
| board_reset_req | output | 1 | One-cycle legacy board reset request |

## Verification
A wrong status or control value is visible on the very next read of offset 0xA8 or 0xA4, so the bench reads back after every random write. A wrong command compare, or a wrong lock state, shows up as a missing or extra request pulse in the single cycle after the write. The bench samples that cycle and the cycle after it, so a pulse that is late, early or too long is caught within two cycles. Errors in variant gating show at once as a non-zero read or a missing bad_addr pulse one cycle after the access.

// File: rtl/brd_cfg_regs.sv
module brd_cfg_regs #(
  parameter int          ID_W         = 12,
  parameter int          AW           = 8,
  parameter logic [11:0] CFG_BOARD_ID = 12'h190,
  parameter logic [31:0] UNLOCK_KEY   = 32'h0000_A05F,
  parameter logic [31:0] CMD_SHUTDOWN = 32'hC080_0000,
  parameter logic [31:0] CMD_REBOOT   = 32'hC090_0000,
  parameter logic [31:0] CTRL_CLR     = 32'h000C_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ID_W-1:0] board_id,
  input  logic [AW-1:0]   addr,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  output logic            bad_addr,
  output logic            shutdown_req,
  output logic            reboot_req,
  output logic            board_reset_req
);
  localparam logic [AW-1:0] OFS_LOCK = AW'(8'h20);
  localparam logic [AW-1:0] OFS_RCTL = AW'(8'h40);
  localparam logic [AW-1:0] OFS_DATA = AW'(8'hA0);
  localparam logic [AW-1:0] OFS_CTRL = AW'(8'hA4);
  localparam logic [AW-1:0] OFS_STAT = AW'(8'hA8);

  logic [31:0] lock_q, rlvl_q, data_q, ctrl_q;
  logic [1:0]  stat_q;

  wire cfg_on   = (board_id == ID_W'(CFG_BOARD_ID));
  wire hit_lock = (addr == OFS_LOCK);
  wire hit_rctl = (addr == OFS_RCTL);
  wire hit_data = cfg_on && (addr == OFS_DATA);
  wire hit_ctrl = cfg_on && (addr == OFS_CTRL);
  wire hit_stat = cfg_on && (addr == OFS_STAT);
  wire mapped   = hit_lock | hit_rctl | hit_data | hit_ctrl | hit_stat;

  wire [31:0] ctrl_in  = wdata & ~CTRL_CLR;
  wire        is_shut  = (ctrl_in == CMD_SHUTDOWN);
  wire        is_boot  = (ctrl_in == CMD_REBOOT);
  wire        unlocked = (lock_q == UNLOCK_KEY);
  wire        rctl_wr  = wr_en && hit_rctl && !cfg_on && unlocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q          <= '0;
      rlvl_q          <= '0;
      data_q          <= '0;
      ctrl_q          <= '0;
      stat_q          <= '0;
      bad_addr        <= 1'b0;
      shutdown_req    <= 1'b0;
      reboot_req      <= 1'b0;
      board_reset_req <= 1'b0;
    end else begin
      bad_addr        <= (wr_en || rd_en) && !mapped;
      shutdown_req    <= wr_en && hit_ctrl && is_shut;
      reboot_req      <= wr_en && hit_ctrl && is_boot;
      board_reset_req <= rctl_wr && wdata[8];
      if (wr_en) begin
        if (hit_lock) lock_q <= wdata;
        if (rctl_wr)  rlvl_q <= wdata;
        if (hit_data) data_q <= wdata;
        if (hit_ctrl) begin
          ctrl_q <= ctrl_in;
          stat_q <= {!(is_shut || is_boot), 1'b1};
        end
        if (hit_stat) stat_q <= wdata[1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_lock)              rdata = lock_q;
    if (hit_rctl && !cfg_on)   rdata = rlvl_q;
    if (hit_data)              rdata = data_q;
    if (hit_ctrl)              rdata = ctrl_q;
    if (hit_stat)              rdata = {30'd0, stat_q};
  end

  p_stat_done_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cfg_on && addr == OFS_CTRL) |=> stat_q[0]);

  p_err_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cfg_on && addr == OFS_CTRL) |=> (stat_q[1] == !(shutdown_req || reboot_req)));

  p_shut_source_r5: assert property (@(posedge clk) disable iff (rst)
    shutdown_req |-> $past(wr_en && cfg_on && addr == OFS_CTRL));

  p_boot_source_r6: assert property (@(posedge clk) disable iff (rst)
    reboot_req |-> $past(wr_en && cfg_on && addr == OFS_CTRL));

  p_req_excl_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({shutdown_req, reboot_req}));

  p_lock_gate_r11: assert property (@(posedge clk) disable iff (rst)
    board_reset_req |-> $past(lock_q == UNLOCK_KEY && !cfg_on));

  p_gated_read_r9: assert property (@(posedge clk) disable iff (rst)
    (!cfg_on && (addr == OFS_DATA || addr == OFS_CTRL || addr == OFS_STAT)) |-> (rdata == 32'd0));

  p_rctl_raz_r10: assert property (@(posedge clk) disable iff (rst)
    (cfg_on && addr == OFS_RCTL) |-> (rdata == 32'd0));
endmodule

// File: tb/brd_cfg_regs_tb_top.sv
`timescale 1ns/1ps
module brd_cfg_regs_tb_top;
  localparam logic [31:0] KEY   = 32'h0000_A05F;
  localparam logic [31:0] SHUT  = 32'hC080_0000;
  localparam logic [31:0] BOOT  = 32'hC090_0000;
  localparam logic [11:0] CFGID = 12'h190;

  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [11:0] board_id = CFGID;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic bad_addr, shutdown_req, reboot_req, board_reset_req;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_lock = 0, m_rlvl = 0, m_data = 0, m_ctrl = 0, m_stat = 0;

  always #10 clk = ~clk;

  brd_cfg_regs dut_i (.clk, .rst, .board_id, .addr, .wr_en, .rd_en, .wdata,
                      .rdata, .bad_addr, .shutdown_req, .reboot_req, .board_reset_req);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit cfg_on();
    return board_id == CFGID;
  endfunction

  function automatic bit cfg_ofs(input logic [7:0] a);
    return a == 8'hA0 || a == 8'hA4 || a == 8'hA8;
  endfunction

  function automatic bit exp_bad(input logic [7:0] a);
    return !(a == 8'h20 || a == 8'h40 || (cfg_on() && cfg_ofs(a)));
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h20: return m_lock;
      8'h40: return cfg_on() ? 32'd0 : m_rlvl;
      8'hA0: return cfg_on() ? m_data : 32'd0;
      8'hA4: return cfg_on() ? m_ctrl : 32'd0;
      8'hA8: return cfg_on() ? m_stat : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  task automatic wr(input string req, input logic [7:0] a, input logic [31:0] d);
    logic [2:0] ep = 3'b000;
    bit eb = exp_bad(a);
    case (a)
      8'h20: m_lock = d;
      8'h40: if (!cfg_on() && m_lock == KEY) begin m_rlvl = d; ep[0] = d[8]; end
      8'hA0: if (cfg_on()) m_data = d;
      8'hA4: if (cfg_on()) begin
        m_ctrl = d & 32'hFFF3_FFFF;
        ep[2] = (m_ctrl == SHUT);
        ep[1] = (m_ctrl == BOOT);
        m_stat = (ep[2] || ep[1]) ? 32'd1 : 32'd3;
      end
      8'hA8: if (cfg_on()) m_stat = d & 32'd3;
      default: ;
    endcase
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
    check({req, " pulses after write"}, {29'd0, shutdown_req, reboot_req, board_reset_req}, {29'd0, ep});
    check({req, " R13 bad flag on write"}, {31'd0, bad_addr}, {31'd0, eb});
    @(negedge clk);
    check("R12 pulses single cycle", {28'd0, shutdown_req, reboot_req, board_reset_req, bad_addr}, 32'd0);
  endtask

  task automatic rd(input string req, input logic [7:0] a);
    logic [31:0] e = exp_read(a);
    bit eb = exp_bad(a);
    @(negedge clk); addr = a; rd_en = 1;
    #1 check({req, " read"}, rdata, e);
    @(negedge clk); rd_en = 0;
    check({req, " R13 bad flag on read"}, {31'd0, bad_addr}, {31'd0, eb});
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250311));
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 idle outputs", {28'd0, shutdown_req, reboot_req, board_reset_req, bad_addr}, 32'd0);
    rd("R1", 8'h20); rd("R1", 8'hA0); rd("R1", 8'hA4); rd("R1", 8'hA8); rd("R1", 8'h40);
    board_id = 12'h140; rd("R1", 8'h40); board_id = CFGID;

    wr("R2", 8'hA0, 32'hDEAD_BEEF); rd("R2", 8'hA0);
    wr("R3", 8'hA4, 32'hFFFF_FFFF); rd("R3", 8'hA4); rd("R7", 8'hA8);
    wr("R8", 8'hA8, 32'hFFFF_FFFE); rd("R8", 8'hA8);
    wr("R4", 8'hA8, 32'd2); wr("R4", 8'hA4, SHUT); rd("R4", 8'hA8);
    wr("R5", 8'hA4, 32'hC08C_0000); rd("R5", 8'hA4); rd("R5", 8'hA8);
    wr("R6", 8'hA4, BOOT); rd("R6", 8'hA8);
    wr("R6", 8'hA4, 32'hC094_0000);
    wr("R7", 8'hA4, 32'hC080_0001); rd("R7", 8'hA8);
    wr("R10", 8'h20, KEY); wr("R10", 8'h40, 32'h0000_0105); rd("R10", 8'h40);

    board_id = 12'h140;
    wr("R9", 8'hA0, 32'h1234_5678); wr("R9", 8'hA4, SHUT); rd("R9", 8'hA0); rd("R9", 8'hA8);
    wr("R11", 8'h20, 32'd0); wr("R11", 8'h40, 32'h0000_0100); rd("R11", 8'h40);
    wr("R11", 8'h20, KEY); wr("R11", 8'h40, 32'h0000_0123); rd("R11", 8'h40);
    board_id = CFGID; rd("R9", 8'hA0);
    rd("R13", 8'hA1); wr("R13", 8'hFC, 32'hFFFF_FFFF); rd("R13", 8'h44);

    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      int sel = $urandom_range(0, 7);
      if ($urandom_range(0, 15) == 0) board_id = ($urandom_range(0, 1) != 0) ? CFGID : 12'h178;
      case (sel)
        0: a = 8'h20; 1: a = 8'h40; 2: a = 8'hA0; 3, 4: a = 8'hA4; 5: a = 8'hA8;
        6: a = 8'h90 + 8'($urandom_range(0, 3) * 4);
        default: a = 8'($urandom_range(0, 255));
      endcase
      case ($urandom_range(0, 4))
        0: d = SHUT | (32'($urandom_range(0, 3)) << 18);
        1: d = BOOT | (32'($urandom_range(0, 3)) << 18);
        2: d = ($urandom_range(0, 1) != 0) ? KEY : 32'h0000_0100 | 32'($urandom_range(0, 255));
        default: d = $urandom;
      endcase
      if ($urandom_range(0, 1) != 0) wr("R12 random", a, d);
      rd("R12 random", a);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule